// File: doc/BRIEF.md
# Memory Read Bus Sequencer

This block sits between a processor core and a slow memory. It turns a one-cycle read request from the core into a fixed multi-cycle bus access. The sequence has four parts. The block first puts the address on the address bus. It then pulls the active-low read strobe low. It holds the strobe low for a set number of wait cycles so the memory has time to answer. Finally it releases the strobe and latches the data bus on that same edge.

The latched word goes back to the core together with a one-cycle completion pulse. Only one read is in flight at a time. While a read is running, the busy output is high and further requests are dropped. The wait length is a parameter and defaults to one cycle. The memory does not report readiness, so the timing is fixed.

Top module: `mem_read_seq`

## Requirements
- R1: After reset, and whenever no access is running, `busy` and `done` are 0 and `bus_rd_n` is 1. The strobe is active low, so 1 means inactive.
- R2: A request is accepted on a rising edge where `req` is 1 and both `busy` and `done` are 0. In the cycle after that edge, `busy` is 1, `bus_addr` equals the requested address and `bus_rd_n` is still 1.
- R3: `bus_addr` does not change while `busy` is 1. After the access ends, it keeps its last value until the next request is accepted.
- R4: `bus_rd_n` goes low one cycle after the address first appears. It then stays low for exactly 1 + WAIT_CYC consecutive cycles.
- R5: On the edge where `bus_rd_n` returns high, `bus_data` is latched into `rdata`. On that same edge `done` rises for exactly one cycle and `busy` falls.
- R6: A request presented while `busy` or `done` is 1 is ignored. It starts no second access, and `rdata` holds the word read for the accepted address.
- R7: `done` is first seen high WAIT_CYC + 2 rising edges after the accepting edge.
- R8: Asserting reset in the middle of an access abandons it. The block returns to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request from the core |
| req_addr | input | ADDR_W | Address to read |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse: `rdata` is valid |
| rdata | output | DATA_W | Word returned to the core |
| bus_addr | output | ADDR_W | Memory address bus |
| bus_rd_n | output | 1 | Memory read strobe, active low |
| bus_data | input | DATA_W | Memory data bus |

## Verification
The bench's memory model drives a valid word only after the strobe has been low for at least one full cycle, and drives a filler value (0xEE) at all other times. A sequencer that skipped the wait cycle, or latched one edge too early, would therefore return the filler value instead of the expected word.

The bench counts the strobe-low cycles and the edges up to `done` on every read. An off-by-one wait counter shows up as a wrong count. A request held high through the busy cycles and the `done` cycle targets a rival address. A sequencer that accepted it would either return that address's word or raise `busy` again after `done`. A reset pulled in the middle of an access must leave the strobe released.

// File: rtl/mem_read_seq.sv
module mem_read_seq #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  input  logic [DATA_W-1:0] bus_data
);
  localparam int CW   = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam int LAST = (WAIT_CYC > 0) ? WAIT_CYC - 1 : 0;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} state_t;

  state_t        state;
  logic [CW-1:0] wcnt;
  logic          accept, finish;

  assign busy   = (state != S_IDLE);
  assign accept = (state == S_IDLE) && req && !done;
  assign finish = ((state == S_STROBE) && (WAIT_CYC == 0)) ||
                  ((state == S_HOLD) && (wcnt == CW'(LAST)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wcnt     <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      bus_addr <= '0;
      bus_rd_n <= 1'b1;
    end else begin
      done <= 1'b0;
      if (accept) begin
        bus_addr <= req_addr;
        state    <= S_SETUP;
      end else if (state == S_SETUP) begin
        bus_rd_n <= 1'b0;
        state    <= S_STROBE;
      end else if (finish) begin
        rdata    <= bus_data;
        bus_rd_n <= 1'b1;
        done     <= 1'b1;
        state    <= S_IDLE;
      end else if (state == S_STROBE) begin
        wcnt  <= '0;
        state <= S_HOLD;
      end else if (state == S_HOLD) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_read_seq_chk.sv
module mem_read_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd_n
);
  a_r1_idle_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_rd_n);

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && !done) |=> (busy && bus_rd_n));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));

  a_r4_strobe_release_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> done);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_no_restart_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind mem_read_seq mem_read_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .bus_addr(bus_addr), .bus_rd_n(bus_rd_n)
);

// File: tb/mem_read_seq_test.sv
`timescale 1ns/1ps
module mem_read_seq_test;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int WC = 1;
  localparam int NV = 6;
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {16'h0000, 8'h5A}, {16'h00FF, 8'hA5}, {16'h1234, 8'h7C},
    {16'hABCD, 8'h3C}, {16'h8001, 8'hDB}, {16'h7F00, 8'h25}
  };

  logic clk = 0, rst_n = 0, req = 0;
  logic [AW-1:0] req_addr = '0;
  logic busy, done, bus_rd_n;
  logic [DW-1:0] rdata, bus_data;
  logic [AW-1:0] bus_addr;
  logic rd_low_q;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  mem_read_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(WC)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .busy(busy), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_data(bus_data));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_low_q <= 1'b0; else rd_low_q <= !bus_rd_n;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign bus_data = (!bus_rd_n && rd_low_q) ? mem_word(bus_addr) : 8'hEE;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input bit rival);
    int n = 0, lows = 0;
    bit addr_ok = 1;
    @(negedge clk); req = 1; req_addr = a;
    @(negedge clk); n = 1;
    check("R2 busy after accept", busy, 1);
    check("R2 address presented", bus_addr, a);
    check("R2 strobe still high", bus_rd_n, 1);
    if (rival) req_addr = ~a; else req = 0;
    while (!done && n < 20) begin
      if (!bus_rd_n) lows++;
      if (bus_addr !== a) addr_ok = 0;
      @(negedge clk); n++;
    end
    check("R7 edges to done", n - 1, WC + 2);
    check("R4 strobe low cycles", lows, WC + 1);
    check("R3 address stable", addr_ok, 1);
    check("R5 data latched", rdata, exp);
    check("R5 strobe released", bus_rd_n, 1);
    check("R5 busy falls with done", busy, 0);
    @(negedge clk); req = 0;
    check("R5 done single pulse", done, 0);
    if (rival) check("R6 no second access", busy, 0);
    check("R3 address held idle", bus_addr, a);
    check("R6 rdata kept", rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    check("R1 reset strobe", bus_rd_n, 1);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      do_read(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], 0);
    do_read(16'h5A5A, mem_word(16'h5A5A), 1);
    do_read(16'hFFFF, mem_word(16'hFFFF), 1);
    @(negedge clk); req = 1; req_addr = 16'h2222;
    @(negedge clk); req = 0;
    @(negedge clk);
    check("R8 strobe low before reset", bus_rd_n, 0);
    rst_n = 0;
    @(negedge clk);
    check("R8 busy cleared", busy, 0);
    check("R8 strobe released", bus_rd_n, 1);
    check("R8 done clear", done, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 idle stays quiet", {busy, done, bus_rd_n}, 3'b001);
    do_read(16'h1234, 8'h7C, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule